// File: doc/BRIEF.md
# Supply Monitor Wake Sequencer

This block watches the supply during a low-power cyclic wake state in which the high-side outputs are off. Two analog comparators outside the block report, as digital flags, whether the supply is above its load threshold and whether it is below its reset threshold. Both flags pass through two-flop synchronisers. While the supply stays above the load threshold the block only monitors it, and the regulator stays off.

When the supply drops below the load threshold, the block turns the regulator on for a fixed charge interval of 1 ms and then judges the supply. If the supply has been below the reset threshold for more than 3 µs in a row, the block waits a further filter delay and then issues a one-cycle reset request. If not, it goes back to monitoring. All intervals are counted in clock cycles derived from a clock-frequency parameter.

Top module: `supv_wake_seq`

## Requirements
- R1: While rst_ni is low, and afterwards as long as load_ok_i stays high, reg_en_o and rst_req_o are both low.
- R2: When load_ok_i falls while the block is monitoring, reg_en_o rises after the third rising clock edge: two synchroniser stages and one state register.
- R3: Once raised, reg_en_o stays high for exactly CHARGE_CYC cycles (1000 at the 1 MHz default), whatever load_ok_i does meanwhile.
- R4: If uv_i is low when the charge interval ends, the block returns to monitoring with no reset request. reg_en_o stays low until load_ok_i is low again.
- R5: A supply dip counts as qualified only when the synchronised uv_i has been high for more than QUAL_CYC consecutive cycles (3 by default). Any low sample restarts the count, so dips of QUAL_CYC cycles or fewer never cause a reset request.
- R6: If the dip is already qualified when the charge interval ends, rst_req_o rises FILT_CYC+1 cycles (65 by default) after reg_en_o falls: one judging cycle plus the filter delay.
- R7: rst_req_o is exactly one cycle wide, and reg_en_o is low while it is high.
- R8: After a reset request the block returns to monitoring. If load_ok_i is still low, a new charge begins two cycles after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; its frequency is CLK_HZ |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_ok_i | input | 1 | Comparator flag, high when the supply is above the load threshold (asynchronous) |
| uv_i | input | 1 | Comparator flag, high when the supply is below the reset threshold (asynchronous) |
| reg_en_o | output | 1 | Regulator enable, high only during the charge interval |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The assertions check on every cycle that the reset request lasts one cycle and never overlaps the regulator enable, that each enable run is exactly the charge length, that an enable only starts after a low synchronised load flag, and that a request comes no sooner than the filter delay after the charge. Only the bench scenarios can show the actual latencies from the flag inputs, that repeated short dips never qualify, that the block returns to monitoring when the supply recovers, and that a charge follows again after a request while the supply stays low.

// File: rtl/supv_wake_pkg.sv
package supv_wake_pkg;

  typedef enum logic [2:0] {
    ST_MONITOR = 3'd0,
    ST_CHARGE  = 3'd1,
    ST_JUDGE   = 3'd2,
    ST_FILTER  = 3'd3,
    ST_PULSE   = 3'd4
  } seq_state_e;

  function automatic int cyc_from_us(input int clk_hz, input int us);
    return (clk_hz / 1_000_000) * us;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg1_q, stg2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg1_q <= RST_VAL;
      stg2_q <= RST_VAL;
    end else begin
      stg1_q <= d_i;
      stg2_q <= stg1_q;
    end
  end

  assign q_o = stg2_q;

endmodule

// File: rtl/supv_dip_qual.sv
// Counts consecutive high samples of the flag; any low sample restarts the count.
module supv_dip_qual #(
  parameter int QUAL_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flag_i,
  output logic qual_o
);

  localparam int QW = $clog2(QUAL_CYC + 2);
  localparam logic [QW-1:0] QMAX = QW'(QUAL_CYC);

  logic [QW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (!flag_i) begin
      run_q <= '0;
    end else if (run_q != QMAX) begin
      run_q <= run_q + 1'b1;
    end
  end

  // qualified on the (QUAL_CYC+1)-th consecutive high sample
  assign qual_o = flag_i && (run_q == QMAX);

endmodule

// File: rtl/supv_interval_timer.sv
module supv_interval_timer #(
  parameter int MAX_CYC = 1000
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic [$clog2(MAX_CYC+1)-1:0] load_val_i,
  output logic                        expired_o
);

  localparam int TW = $clog2(MAX_CYC + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/supv_wake_seq.sv
module supv_wake_seq
  import supv_wake_pkg::*;
#(
  parameter int CLK_HZ    = 1_000_000,
  parameter int CHARGE_US = 1000,
  parameter int QUAL_US   = 3,
  parameter int FILT_CYC  = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_ok_i,
  input  logic uv_i,
  output logic reg_en_o,
  output logic rst_req_o
);

  localparam int CHARGE_CYC = cyc_from_us(CLK_HZ, CHARGE_US);
  localparam int QUAL_CYC   = cyc_from_us(CLK_HZ, QUAL_US);
  localparam int TMR_MAX    = max2(CHARGE_CYC, FILT_CYC);
  localparam int TW         = $clog2(TMR_MAX + 1);
  localparam logic [TW-1:0] CHARGE_LD = TW'(CHARGE_CYC - 1);
  localparam logic [TW-1:0] FILT_LD   = TW'(FILT_CYC - 1);

  logic       load_ok_s, uv_s;
  logic       dip_qual;
  logic       tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;
  seq_state_e state_q, state_d;

  // load flag resets high so that a reset never starts a spurious charge
  supv_sync #(.WIDTH(2), .RST_VAL(2'b10)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({load_ok_i, uv_i}),
    .q_o    ({load_ok_s, uv_s})
  );

  supv_dip_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flag_i (uv_s),
    .qual_o (dip_qual)
  );

  supv_interval_timer #(.MAX_CYC(TMR_MAX)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_expired)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = CHARGE_LD;
    unique case (state_q)
      ST_MONITOR: begin
        if (!load_ok_s) begin
          state_d  = ST_CHARGE;
          tmr_load = 1'b1;
          tmr_val  = CHARGE_LD;
        end
      end
      ST_CHARGE: begin
        if (tmr_expired) state_d = ST_JUDGE;
      end
      ST_JUDGE: begin
        // wait here while a dip is present but not yet qualified
        if (dip_qual) begin
          state_d  = ST_FILTER;
          tmr_load = 1'b1;
          tmr_val  = FILT_LD;
        end else if (!uv_s) begin
          state_d = ST_MONITOR;
        end
      end
      ST_FILTER: begin
        if (tmr_expired) state_d = ST_PULSE;
      end
      ST_PULSE: state_d = ST_MONITOR;
      default:  state_d = ST_MONITOR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_MONITOR;
    else         state_q <= state_d;
  end

  assign reg_en_o  = (state_q == ST_CHARGE);
  assign rst_req_o = (state_q == ST_PULSE);

endmodule

// File: rtl/supv_wake_seq_chk.sv
module supv_wake_seq_chk #(
  parameter int CHARGE_CYC = 1000,
  parameter int FILT_CYC   = 64
) (
  input logic clk_i,
  input logic rst_ni,
  input logic load_ok_s,
  input logic reg_en_o,
  input logic rst_req_o
);

  localparam int CW = $clog2(CHARGE_CYC + 2);
  localparam int GW = $clog2(FILT_CYC + 3);
  localparam logic [CW-1:0] CMAX = CW'(CHARGE_CYC + 1);
  localparam logic [GW-1:0] GMAX = GW'(FILT_CYC + 2);

  logic [CW-1:0] en_run_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_run_q <= '0;
      gap_q    <= '0;
    end else begin
      if (!reg_en_o)            en_run_q <= '0;
      else if (en_run_q != CMAX) en_run_q <= en_run_q + 1'b1;
      if (reg_en_o)             gap_q <= '0;
      else if (gap_q != GMAX)   gap_q <= gap_q + 1'b1;
    end
  end

  a_r7_pulse_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  a_r7_no_en_during_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> !reg_en_o);

  a_r3_charge_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reg_en_o) |-> (en_run_q == CW'(CHARGE_CYC)));

  a_r2_charge_needs_low_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_en_o) |-> !$past(load_ok_s));

  a_r6_filter_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (gap_q >= GW'(FILT_CYC + 1)));

endmodule

bind supv_wake_seq supv_wake_seq_chk #(
  .CHARGE_CYC (CHARGE_CYC),
  .FILT_CYC   (FILT_CYC)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_ok_s (load_ok_s),
  .reg_en_o  (reg_en_o),
  .rst_req_o (rst_req_o)
);

// File: tb/supv_wake_seq_bench.sv
`timescale 1ns/1ps
module supv_wake_seq_bench;

  localparam int CHARGE_CYC = 1000;
  localparam int QUAL_CYC   = 3;
  localparam int FILT_CYC   = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_ok = 1'b1;
  logic uv = 1'b0;
  logic reg_en, rst_req;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  supv_wake_seq u_supv_wake_seq (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .load_ok_i (load_ok),
    .uv_i      (uv),
    .reg_en_o  (reg_en),
    .rst_req_o (rst_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    int bad = 0;
    @(negedge clk);
    chk(!reg_en && !rst_req, "R1 outputs in reset", {reg_en, rst_req}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (reg_en || rst_req) bad++;
    end
    chk(bad == 0, "R1 idle while load ok", bad, 0);
  endtask

  task automatic t_charge_recover;
    int k = 0, n = 0, bad = 0;
    load_ok = 1'b0;
    uv = 1'b0;
    do begin
      @(negedge clk);
      k++;
    end while (!reg_en && k < 20);
    chk(k == 3, "R2 enable latency", k, 3);
    load_ok = 1'b1;  // recovery during charge must not shorten it
    while (reg_en && n < 5000) begin
      n++;
      @(negedge clk);
    end
    chk(n == CHARGE_CYC, "R3 charge length", n, CHARGE_CYC);
    for (int i = 0; i < 200; i++) begin
      if (reg_en || rst_req) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R4 back to monitoring", bad, 0);
  endtask

  task automatic t_reset_issue;
    int n = 0, g = 0, w = 0;
    uv = 1'b1;
    load_ok = 1'b0;
    while (!reg_en && w < 20) begin
      w++;
      @(negedge clk);
    end
    while (reg_en && n < 5000) begin
      n++;
      @(negedge clk);
    end
    chk(n == CHARGE_CYC, "R3 charge length with dip", n, CHARGE_CYC);
    while (!rst_req && g < 500) begin
      g++;
      @(negedge clk);
    end
    chk(g == FILT_CYC + 1, "R6 request delay", g, FILT_CYC + 1);
    chk(!reg_en, "R7 enable low during request", reg_en, 0);
    @(negedge clk);
    chk(!rst_req, "R7 request one cycle", rst_req, 0);
    chk(!reg_en, "R8 monitor after request", reg_en, 0);
    @(negedge clk);
    chk(reg_en, "R8 new charge after request", reg_en, 1);
    load_ok = 1'b1;
    uv = 1'b0;
    for (int i = 0; i < CHARGE_CYC + 20; i++) @(negedge clk);
    chk(!reg_en && !rst_req, "R4 settled after recovery", {reg_en, rst_req}, 0);
  endtask

  task automatic t_brief_dips;
    int reqs = 0, ens = 0, w = 0;
    load_ok = 1'b0;
    for (int i = 0; i < 3 * CHARGE_CYC; i++) begin
      uv = ((i % (QUAL_CYC + 1)) != QUAL_CYC);
      @(negedge clk);
      if (rst_req) reqs++;
      if (reg_en) ens++;
    end
    chk(reqs == 0, "R5 short dips ignored", reqs, 0);
    chk(ens > 0, "R5 charges ran during dips", ens, 1);
    uv = 1'b1;
    while (!rst_req && w < 3 * CHARGE_CYC) begin
      w++;
      @(negedge clk);
    end
    chk(rst_req, "R5 sustained dip qualifies", rst_req, 1);
    load_ok = 1'b1;
    uv = 1'b0;
    for (int i = 0; i < CHARGE_CYC + 20; i++) @(negedge clk);
  endtask

  task automatic t_idle_again;
    int bad = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (reg_en || rst_req) bad++;
    end
    chk(bad == 0, "R1 idle with load ok", bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_charge_recover();
    t_reset_issue();
    t_brief_dips();
    t_idle_again();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150_000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule